// File: doc/BRIEF.md
# Pattern-Driven Detector Clock Sequencer

This block produces the clock waveforms and conversion strobes that drive a detector readout. The host loads two memories while the block is idle: a pattern memory, where each word is one waveform state (the level of every clock line, a strobe bit, a hold time and a last-state marker), and a program memory, where each word is a short instruction. An instruction can run a stored pattern a given number of times, branch, end the program or do nothing.

A start pulse runs the program from its first word. Each run instruction steps through its pattern from the given start address. Every state is held for its own number of cycles. When the marked last state has been held for its full time, the pattern starts again immediately if repeats remain. Otherwise the next instruction is fetched. A stop request ends the run cleanly at the next pattern boundary. While the run is in progress, host writes to either memory are discarded, so a program cannot be altered in the middle of a readout.

Top module: `rdo_sequencer`

## Requirements
- R1: A pattern word is 28 bits: bits [17:0] set `clk_lines`, bit 18 sets `conv_strobe`, bits [26:19] are the hold value and bit 27 marks the last state. When a state is entered, its clock bits and strobe bit appear on the outputs.
- R2: A state with hold value H drives the outputs for exactly H+1 cycles. The next state follows at the next address with no gap.
- R3: When the last state of a pattern ends and repeats remain, the pattern restarts at its start address in the very next cycle.
- R4: A program word is 16 bits: opcode in bits [15:14], address field in bits [13:8] and repeat count in bits [7:0]. Opcode 00 runs the pattern that starts at the address field, repeat-count times. Every instruction takes one fetch cycle, and the first pattern state appears in the cycle after that fetch.
- R5: A run instruction with repeat count 0 skips the pattern. The program continues with the next word and no state is output.
- R6: Opcode 01 continues the program at the address held in bits [12:8].
- R7: Opcode 10 ends the program and drops `busy`. Opcode 11 does nothing but moves to the next word.
- R8: A `start` pulse while idle begins the program at word 0 and raises `busy` in the next cycle. `start` has no effect while `busy` is high.
- R9: `stop` takes effect only when the current pattern finishes (or at once during a fetch). `busy` then drops, `clk_lines` keep the last state's levels and `conv_strobe` is low whenever `busy` is low.
- R10: Writes to either memory are discarded while `busy` is high.
- R11: After reset, `busy`, `clk_lines` and `conv_strobe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_we | input | 1 | Pattern memory write enable |
| pat_waddr | input | 6 | Pattern memory write address |
| pat_wdata | input | 28 | Pattern word to write |
| seq_we | input | 1 | Program memory write enable |
| seq_waddr | input | 5 | Program memory write address |
| seq_wdata | input | 16 | Program word to write |
| start | input | 1 | Begin the program at word 0 |
| stop | input | 1 | Request a halt at the next pattern boundary |
| busy | output | 1 | High while the program runs |
| clk_lines | output | 18 | Detector clock levels |
| conv_strobe | output | 1 | Conversion strobe of the current state |

## Verification
The assertions check these rules on every cycle: the outputs stay still while a state is being held and while the block is idle, the strobe stays low when the block is not busy, a running pattern always has a repeat count left, the block leaves a pattern early only when a stop was requested, and memory writes are discarded while busy. The bench scenarios show the behaviours that depend on a whole program: exact state timing, back-to-back repeats, skipped patterns, branches, the total run length, the final held levels and whether a program or pattern written during a run is left unchanged afterwards.

// File: rtl/rdo_seq_pkg.sv
// Shared types for the pattern sequencer: program opcodes and the
// engine state encoding. No parameters live here; widths are set per
// instance by the top module.
package rdo_seq_pkg;

    typedef enum logic [1:0] {
        OP_EXEC = 2'b00,
        OP_JUMP = 2'b01,
        OP_END  = 2'b10,
        OP_NOP  = 2'b11
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2
    } eng_state_e;

endpackage

// File: rtl/rdo_ram.sv
// Host-loaded storage array with one write port and one combinational
// read port. Writes are discarded while lock is high (the engine is
// running). Assumes the host holds its write inputs stable for one clock.
module rdo_ram #(
    parameter int W  = 28,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store a host word when the engine is not running.
    always_ff @(posedge clk) begin
        if (we && !lock) begin
            mem[waddr] <= wdata;
        end
    end

    // Read the addressed word without a register stage.
    always_comb begin
        rdata = mem[raddr];
    end

    // R10
    wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/rdo_engine.sv
// Two-level interpreter: fetches program words, and for each run
// instruction steps through a stored pattern, holding each state for its
// own dwell and repeating the pattern back to back. Both memories are
// read combinationally, so a fetched word is decoded in the same cycle.
// Assumes the address field is wide enough for both memories.
module rdo_engine
    import rdo_seq_pkg::*;
#(
    parameter int CLK_W  = 18,
    parameter int RSP_W  = 8,
    parameter int REP_W  = 8,
    parameter int PAT_AW = 6,
    parameter int SEQ_AW = 5,
    localparam int AF_W  = (PAT_AW > SEQ_AW) ? PAT_AW : SEQ_AW,
    localparam int PW    = CLK_W + RSP_W + 2,
    localparam int INS_W = 2 + AF_W + REP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [INS_W-1:0]  ins_i,
    output logic [SEQ_AW-1:0] seq_raddr_o,
    input  logic [PW-1:0]     pat_word_i,
    output logic [PAT_AW-1:0] pat_raddr_o,
    output logic              busy_o,
    output logic [CLK_W-1:0]  clk_lines_o,
    output logic              strobe_o
);
    eng_state_e        state_q;
    logic [SEQ_AW-1:0] seq_pc_q;
    logic [PAT_AW-1:0] pat_pc_q;
    logic [PAT_AW-1:0] pat_base_q;
    logic [REP_W-1:0]  rep_q;
    logic [RSP_W-1:0]  dwell_q;
    logic              last_q;
    logic [CLK_W-1:0]  lvl_q;
    logic              stb_q;
    logic              stop_pend_q;

    seq_op_e           op;
    logic [AF_W-1:0]   fld_addr;
    logic [REP_W-1:0]  fld_rep;
    logic              stop_now;
    logic [PAT_AW-1:0] pat_next;

    // Split the fetched program word into its fields.
    always_comb begin
        op       = seq_op_e'(ins_i[INS_W-1 -: 2]);
        fld_addr = ins_i[REP_W +: AF_W];
        fld_rep  = ins_i[REP_W-1:0];
        stop_now = stop_pend_q | stop_i;
    end

    // Pick the pattern address whose word is loaded at the next edge.
    always_comb begin
        pat_next = PAT_AW'(pat_pc_q + 1'b1);
        if (state_q == ST_FETCH) begin
            pat_raddr_o = fld_addr[PAT_AW-1:0];
        end else if (state_q == ST_RUN && last_q) begin
            pat_raddr_o = pat_base_q;
        end else begin
            pat_raddr_o = pat_next;
        end
    end

    // Remember a stop request until the run actually ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pend_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            stop_pend_q <= 1'b0;
        end else if (stop_i) begin
            stop_pend_q <= 1'b1;
        end
    end

    // Interpret program words and step the active pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            seq_pc_q   <= '0;
            pat_pc_q   <= '0;
            pat_base_q <= '0;
            rep_q      <= '0;
            dwell_q    <= '0;
            last_q     <= 1'b0;
            lvl_q      <= '0;
            stb_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        seq_pc_q <= '0;
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (stop_now) begin
                        state_q <= ST_IDLE;
                        stb_q   <= 1'b0;
                    end else begin
                        case (op)
                            OP_EXEC: begin
                                seq_pc_q <= SEQ_AW'(seq_pc_q + 1'b1);
                                if (fld_rep != '0) begin
                                    pat_pc_q   <= fld_addr[PAT_AW-1:0];
                                    pat_base_q <= fld_addr[PAT_AW-1:0];
                                    rep_q      <= fld_rep;
                                    lvl_q      <= pat_word_i[CLK_W-1:0];
                                    stb_q      <= pat_word_i[CLK_W];
                                    dwell_q    <= pat_word_i[CLK_W+1 +: RSP_W];
                                    last_q     <= pat_word_i[PW-1];
                                    state_q    <= ST_RUN;
                                end
                            end
                            OP_JUMP: seq_pc_q <= fld_addr[SEQ_AW-1:0];
                            OP_END:  state_q  <= ST_IDLE;
                            default: seq_pc_q <= SEQ_AW'(seq_pc_q + 1'b1);
                        endcase
                    end
                end
                ST_RUN: begin
                    if (dwell_q != '0) begin
                        dwell_q <= dwell_q - 1'b1;
                    end else if (!last_q || (!stop_now && rep_q > 1)) begin
                        if (last_q) begin
                            rep_q <= rep_q - 1'b1;
                        end
                        pat_pc_q <= pat_raddr_o;
                        lvl_q    <= pat_word_i[CLK_W-1:0];
                        stb_q    <= pat_word_i[CLK_W];
                        dwell_q  <= pat_word_i[CLK_W+1 +: RSP_W];
                        last_q   <= pat_word_i[PW-1];
                    end else begin
                        stb_q   <= 1'b0;
                        state_q <= stop_now ? ST_IDLE : ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign seq_raddr_o = seq_pc_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign clk_lines_o = lvl_q;
    assign strobe_o    = stb_q;

    // R2
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && dwell_q != '0) |=> ($stable(lvl_q) && $stable(stb_q)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(lvl_q));

    // R9
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !strobe_o);

    // R5
    rep_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (rep_q != '0));

    // R9
    no_early_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stop_pend_q && !stop_i) |=> (state_q != ST_IDLE));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> busy_o);

endmodule

// File: rtl/rdo_sequencer.sv
// Top of the pattern sequencer: two host-loaded memories (patterns and
// program) feeding the interpreter engine. The engine's busy flag locks
// both memories against host writes during a run.
module rdo_sequencer #(
    parameter int CLK_W  = 18,
    parameter int RSP_W  = 8,
    parameter int REP_W  = 8,
    parameter int PAT_AW = 6,
    parameter int SEQ_AW = 5,
    localparam int AF_W  = (PAT_AW > SEQ_AW) ? PAT_AW : SEQ_AW,
    localparam int PW    = CLK_W + RSP_W + 2,
    localparam int INS_W = 2 + AF_W + REP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_we,
    input  logic [PAT_AW-1:0] pat_waddr,
    input  logic [PW-1:0]     pat_wdata,
    input  logic              seq_we,
    input  logic [SEQ_AW-1:0] seq_waddr,
    input  logic [INS_W-1:0]  seq_wdata,
    input  logic              start,
    input  logic              stop,
    output logic              busy,
    output logic [CLK_W-1:0]  clk_lines,
    output logic              conv_strobe
);
    logic [PAT_AW-1:0] pat_raddr;
    logic [PW-1:0]     pat_word;
    logic [SEQ_AW-1:0] seq_raddr;
    logic [INS_W-1:0]  ins_word;

    rdo_ram #(.W(PW), .AW(PAT_AW)) pat_mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (busy),
        .we    (pat_we),
        .waddr (pat_waddr),
        .wdata (pat_wdata),
        .raddr (pat_raddr),
        .rdata (pat_word)
    );

    rdo_ram #(.W(INS_W), .AW(SEQ_AW)) seq_mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (busy),
        .we    (seq_we),
        .waddr (seq_waddr),
        .wdata (seq_wdata),
        .raddr (seq_raddr),
        .rdata (ins_word)
    );

    rdo_engine #(
        .CLK_W(CLK_W), .RSP_W(RSP_W), .REP_W(REP_W),
        .PAT_AW(PAT_AW), .SEQ_AW(SEQ_AW)
    ) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .stop_i      (stop),
        .ins_i       (ins_word),
        .seq_raddr_o (seq_raddr),
        .pat_word_i  (pat_word),
        .pat_raddr_o (pat_raddr),
        .busy_o      (busy),
        .clk_lines_o (clk_lines),
        .strobe_o    (conv_strobe)
    );

endmodule

// File: tb/rdo_sequencer_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a table of programs with hand-computed run length,
// strobe count and final levels, then directed timing, repeat, stop,
// write-lock and reset tests.
module rdo_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we = 1'b0;
    logic [5:0]  pat_waddr = '0;
    logic [27:0] pat_wdata = '0;
    logic        seq_we = 1'b0;
    logic [4:0]  seq_waddr = '0;
    logic [15:0] seq_wdata = '0;
    logic        start_run = 1'b0;
    logic        start_extra = 1'b0;
    logic        start;
    logic        stop = 1'b0;
    logic        busy;
    logic [17:0] clk_lines;
    logic        conv_strobe;

    assign start = start_run | start_extra;

    always #5 clk = ~clk;

    rdo_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata),
        .seq_we(seq_we), .seq_waddr(seq_waddr), .seq_wdata(seq_wdata),
        .start(start), .stop(stop),
        .busy(busy), .clk_lines(clk_lines), .conv_strobe(conv_strobe)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Programs: 0x00aa_rr run pattern at aa rep rr, 0x4t00 jump, 0x8000 end, 0xC000 nop
    localparam logic [15:0] VPROG [0:5][0:4] = '{
        '{16'h0001, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
        '{16'h0003, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
        '{16'h0802, 16'h0000, 16'hC000, 16'h8000, 16'h8000},
        '{16'h0001, 16'h4300, 16'h0805, 16'h0801, 16'h8000},
        '{16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
        '{16'h0801, 16'h0002, 16'h8000, 16'h8000, 16'h8000}
    };
    localparam int          VBUSY [0:5] = '{8, 20, 14, 15, 1, 20};
    localparam int          VSTB  [0:5] = '{1, 3, 8, 5, 0, 6};
    localparam logic [17:0] VFIN  [0:5] = '{18'h20000, 18'h20000, 18'h0AAAA,
                                            18'h0AAAA, 18'h0AAAA, 18'h20000};
    localparam string       VREQ  [0:5] = '{"R4", "R3", "R5", "R6", "R7", "R2"};

    logic [17:0] tr_clk [0:31];
    logic        tr_stb [0:31];
    int          got_busy;
    int          got_stb;
    logic [17:0] got_fin;

    function automatic logic [27:0] mk_word(input logic last, input logic [7:0] hold,
                                            input logic stb, input logic [17:0] lv);
        return {last, hold, stb, lv};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pat_wr(input logic [5:0] a, input logic [27:0] d);
        @(negedge clk);
        pat_we = 1'b1; pat_waddr = a; pat_wdata = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic seq_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        seq_we = 1'b1; seq_waddr = a; seq_wdata = d;
        @(negedge clk);
        seq_we = 1'b0;
    endtask

    // Pulse start, then sample every negedge while busy.
    task automatic run_prog();
        int k;
        got_busy = 0; got_stb = 0;
        for (int i = 0; i < 32; i++) begin tr_clk[i] = '0; tr_stb[i] = 1'b0; end
        @(negedge clk);
        start_run = 1'b1;
        @(negedge clk);
        start_run = 1'b0;
        k = 0;
        while (busy && k < 1000) begin
            if (k < 32) begin tr_clk[k] = clk_lines; tr_stb[k] = conv_strobe; end
            got_busy++;
            if (conv_strobe) got_stb++;
            @(negedge clk);
            k++;
        end
        got_fin = clk_lines;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", busy, 0);
        chk(clk_lines == '0, "R11", clk_lines, 0);
        chk(conv_strobe == 1'b0, "R11", conv_strobe, 0);

        pat_wr(6'd0, mk_word(1'b0, 8'd1, 1'b0, 18'h00001));
        pat_wr(6'd1, mk_word(1'b0, 8'd0, 1'b1, 18'h00003));
        pat_wr(6'd2, mk_word(1'b1, 8'd2, 1'b0, 18'h20000));
        pat_wr(6'd8, mk_word(1'b0, 8'd3, 1'b1, 18'h15555));
        pat_wr(6'd9, mk_word(1'b1, 8'd0, 1'b0, 18'h0AAAA));

        // R1 R2 R4 exact state timing of pattern at 0 run once
        seq_wr(5'd0, 16'h0001);
        seq_wr(5'd1, 16'h8000);
        run_prog();
        chk(tr_clk[0] == 18'h0, "R4", tr_clk[0], 0);
        chk(tr_clk[1] == 18'h00001 && tr_clk[2] == 18'h00001, "R2", tr_clk[2], 1);
        chk(tr_clk[3] == 18'h00003 && tr_stb[3], "R1", tr_clk[3], 3);
        chk(!tr_stb[2] && !tr_stb[4], "R1", tr_stb[4], 0);
        chk(tr_clk[4] == 18'h20000 && tr_clk[6] == 18'h20000, "R2", tr_clk[6], 18'h20000);
        chk(got_busy == 8, "R7", got_busy, 8);

        // Table of programs
        for (int v = 0; v < 6; v++) begin
            for (int w = 0; w < 5; w++) seq_wr(5'(w), VPROG[v][w]);
            run_prog();
            chk(got_busy == VBUSY[v], VREQ[v], got_busy, VBUSY[v]);
            chk(got_stb == VSTB[v], VREQ[v], got_stb, VSTB[v]);
            chk(got_fin == VFIN[v], VREQ[v], got_fin, VFIN[v]);
        end

        // R3 back-to-back repeat
        seq_wr(5'd0, 16'h0802);
        seq_wr(5'd1, 16'h8000);
        run_prog();
        chk(tr_clk[5] == 18'h0AAAA, "R3", tr_clk[5], 18'h0AAAA);
        chk(tr_clk[6] == 18'h15555, "R3", tr_clk[6], 18'h15555);
        chk(got_busy == 12, "R3", got_busy, 12);

        // R9 stop mid-pattern, R8 start while busy ignored
        seq_wr(5'd0, 16'h0805);
        fork
            run_prog();
            begin
                repeat (4) @(negedge clk);
                stop = 1'b1; start_extra = 1'b1;
                @(negedge clk);
                stop = 1'b0; start_extra = 1'b0;
            end
        join
        chk(got_busy == 6, "R9", got_busy, 6);
        chk(got_fin == 18'h0AAAA, "R9", got_fin, 18'h0AAAA);
        chk(conv_strobe == 1'b0, "R9", conv_strobe, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8", busy, 0);

        // R10 writes during a run are discarded
        seq_wr(5'd0, 16'h0003);
        fork
            run_prog();
            begin
                repeat (5) @(negedge clk);
                pat_we = 1'b1; pat_waddr = 6'd0; pat_wdata = mk_word(1'b0, 8'd0, 1'b0, 18'h3FFFF);
                seq_we = 1'b1; seq_waddr = 5'd0; seq_wdata = 16'h8000;
                @(negedge clk);
                pat_we = 1'b0; seq_we = 1'b0;
            end
        join
        run_prog();
        chk(got_busy == 20, "R10", got_busy, 20);
        chk(tr_clk[1] == 18'h00001, "R10", tr_clk[1], 1);

        // R11 reset during a run
        fork
            run_prog();
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
            end
        join
        chk(busy == 1'b0, "R11", busy, 0);
        chk(clk_lines == '0, "R11", clk_lines, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule